// File: doc/BRIEF.md
# Frame Sync Arm Controller

This block decides when a frame-sync event is issued to the rest of a clock-translation path. One of four reference inputs is selected, and each reference is paired with a sync-pulse input. References 0 and 1 use input 1 as their pulse source. References 2 and 3 use input 3. A rising edge on the partner input is treated as a frame pulse. The block turns qualifying pulses into a single-cycle event. It also reports whether the selected reference is valid, optionally requiring the partner input to be valid as well.

Configuration lives in two byte-wide registers. Software writes them through a small write port, and the writes land in shadow storage. The shadow values are copied to the active set only when the update strobe is pulsed. Readback returns the shadow contents.

There are two operating modes. In continuous mode every pulse edge fires an event. In one-shot mode only the first pulse after arming fires an event. Arming comes either from the falling edge of an external sync pin or from a clear-then-set of the software arm bit.

Top module: `fsync_arm_ctrl`

## Requirements
- R1: After reset all fields read 0. Address 0 holds the enable at bit 0, and bits 7:1 read as zero. Address 1 holds the following fields, and bits 7:4 read as zero:
  - bit 0: soft arm
  - bit 1: arm method (0 = pin, 1 = soft bit)
  - bit 2: one-shot
  - bit 3: validate-with-partner
- R2: A register write changes only the shadow copy. Its effect on the block starts on the clock edge where `updateStrobe` is high.
- R3: `selRefValid` is `refValid[refSel]` when validate-with-partner is 0. When it is 1, `selRefValid` also requires `refValid` of the partner input (the selected index with bit 0 forced to 1).
- R4: The pulse source is the partner of the selected reference. Only a 0-to-1 transition of that input counts as a pulse, and pulses on other inputs fire nothing.
- R5: With one-shot at 0 and enable at 1, every pulse produces `fsyncEvent`. The event is high for exactly the one cycle after the edge is sampled.
- R6: With one-shot at 1, a pulse fires only while `armed` is 1. Firing clears `armed`, so later pulses are ignored until the block is rearmed.
- R7: With arm method 0, `armed` is set on the cycle after `syncPin` is seen going from 1 to 0. A high level alone does not arm the block.
- R8: With arm method 1, a 0-to-1 change of the active soft-arm bit sets `armed`. That bit has no effect while arm method is 0. Leaving the bit at 1 while switching the method does not arm the block.
- R9: While the active enable is 0, no event is issued and `armed` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 1 | Register select (0 control, 1 sync config) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Shadow readback of the addressed register |
| updateStrobe | input | 1 | Copies shadow registers to the active set |
| refSel | input | 2 | Selected reference index |
| refValid | input | 4 | Per-input valid flags |
| refPulse | input | 4 | Per-input sync pulse levels |
| syncPin | input | 1 | External arming pin |
| selRefValid | output | 1 | Qualified validity of the selected reference |
| fsyncEvent | output | 1 | Single-cycle frame-sync event |
| armed | output | 1 | Current armed state |

## Verification
Validity qualification is driven from a vector table. The table covers both settings of the partner-check bit and references in both pairs, and separates a reference failing on its own flag from one failing only on its partner's flag.

Pulse handling is then tried in several ways:
- Pulses on the non-partner input and on the partner input, which shows the source mapping is correct.
- Repeated pulses in continuous mode against one-shot mode, which shows disarming after the first event.
- Pin and soft-bit arming with the method set each way, which shows that each arm path is ignored when the other method is active.

Writes that are not yet updated, and clearing the enable, are checked for having no effect at the outputs.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  typedef struct packed {
    logic enable;
    logic validateRef;
    logic oneShot;
    logic armMethod;
    logic softArm;
  } fsync_cfg_t;

  typedef struct packed {
    logic pulseRise;
    logic pinFall;
    logic softRise;
  } fsync_strobe_t;
endpackage

// File: rtl/fsync_regs_dp.sv
module fsync_regs_dp
  import fsync_pkg::*;
#(
  parameter int REF_CNT = 4,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = $clog2(REF_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              updateStrobe,
  input  logic [SEL_W-1:0]  refSel,
  input  logic [REF_CNT-1:0] refValid,
  input  logic [REF_CNT-1:0] refPulse,
  input  logic              syncPin,
  output logic              selRefValid,
  output fsync_cfg_t        activeCfg,
  output fsync_strobe_t     strobes
);
  fsync_cfg_t shadowCfg;
  logic [REF_CNT-1:0] pulsePrev;
  logic syncPrev;
  logic softPrev;
  logic [SEL_W-1:0] partnerIdx;
  logic unusedWr;

  assign unusedWr   = ^regWrData[DATA_W-1:4];
  assign partnerIdx = refSel | SEL_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCfg <= '0;
    end else if (regWrEn) begin
      if (regAddr == 1'b0) begin
        shadowCfg.enable <= regWrData[0];
      end else begin
        shadowCfg.validateRef <= regWrData[3];
        shadowCfg.oneShot     <= regWrData[2];
        shadowCfg.armMethod   <= regWrData[1];
        shadowCfg.softArm     <= regWrData[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) activeCfg <= '0;
    else if (updateStrobe) activeCfg <= shadowCfg;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == 1'b0) begin
      regRdData[0] = shadowCfg.enable;
    end else begin
      regRdData[3:0] = {shadowCfg.validateRef, shadowCfg.oneShot,
                        shadowCfg.armMethod, shadowCfg.softArm};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulsePrev <= '0;
      syncPrev  <= 1'b0;
      softPrev  <= 1'b0;
    end else begin
      pulsePrev <= refPulse;
      syncPrev  <= syncPin;
      softPrev  <= activeCfg.softArm;
    end
  end

  always_comb begin
    strobes.pulseRise = refPulse[partnerIdx] & ~pulsePrev[partnerIdx];
    strobes.pinFall   = syncPrev & ~syncPin;
    strobes.softRise  = activeCfg.softArm & ~softPrev;
  end

  assign selRefValid = refValid[refSel] &
                       (~activeCfg.validateRef | refValid[partnerIdx]);
endmodule

// File: rtl/fsync_arm_fsm.sv
module fsync_arm_fsm
  import fsync_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  fsync_cfg_t    activeCfg,
  input  fsync_strobe_t strobes,
  output logic          fsyncEvent,
  output logic          armed
);
  logic armReq;
  logic fire;
  logic armedNext;

  assign armReq = activeCfg.armMethod ? strobes.softRise : strobes.pinFall;
  assign fire   = activeCfg.enable & strobes.pulseRise &
                  (~activeCfg.oneShot | armed);

  always_comb begin
    armedNext = armed;
    if (!activeCfg.enable)                armedNext = 1'b0;
    else if (armReq)                      armedNext = 1'b1;
    else if (fire && activeCfg.oneShot)   armedNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed      <= 1'b0;
      fsyncEvent <= 1'b0;
    end else begin
      armed      <= armedNext;
      fsyncEvent <= fire;
    end
  end
endmodule

// File: rtl/fsync_arm_ctrl.sv
module fsync_arm_ctrl
  import fsync_pkg::*;
#(
  parameter int REF_CNT = 4,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = $clog2(REF_CNT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               updateStrobe,
  input  logic [SEL_W-1:0]   refSel,
  input  logic [REF_CNT-1:0] refValid,
  input  logic [REF_CNT-1:0] refPulse,
  input  logic               syncPin,
  output logic               selRefValid,
  output logic               fsyncEvent,
  output logic               armed
);
  fsync_cfg_t    activeCfg;
  fsync_strobe_t strobes;

  fsync_regs_dp #(.REF_CNT(REF_CNT), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .updateStrobe(updateStrobe), .refSel(refSel), .refValid(refValid),
    .refPulse(refPulse), .syncPin(syncPin), .selRefValid(selRefValid),
    .activeCfg(activeCfg), .strobes(strobes)
  );

  fsync_arm_fsm u_fsm (
    .clk(clk), .rstN(rstN), .activeCfg(activeCfg), .strobes(strobes),
    .fsyncEvent(fsyncEvent), .armed(armed)
  );
endmodule

// File: rtl/fsync_arm_checker.sv
module fsync_arm_checker #(
  parameter int REF_CNT = 4,
  localparam int SEL_W  = $clog2(REF_CNT)
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               oneShot,
  input logic               validateRef,
  input logic [SEL_W-1:0]   refSel,
  input logic [REF_CNT-1:0] refValid,
  input logic               selRefValid,
  input logic               fsyncEvent,
  input logic               armed
);
  AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    fsyncEvent |=> !fsyncEvent); // R5
  AST_ONESHOT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (fsyncEvent && $past(oneShot)) |-> $past(armed)); // R6
  AST_NO_EVENT_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> !fsyncEvent); // R9
  AST_DISARM_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> !armed); // R9
  AST_VALID_OWN: assert property (@(posedge clk) disable iff (!rstN)
    selRefValid |-> refValid[refSel]); // R3
  AST_VALID_PARTNER: assert property (@(posedge clk) disable iff (!rstN)
    (selRefValid && validateRef) |-> refValid[refSel | SEL_W'(1)]); // R3
endmodule

bind fsync_arm_ctrl fsync_arm_checker #(.REF_CNT(REF_CNT)) u_chk (
  .clk(clk), .rstN(rstN), .enable(activeCfg.enable),
  .oneShot(activeCfg.oneShot), .validateRef(activeCfg.validateRef),
  .refSel(refSel), .refValid(refValid), .selRefValid(selRefValid),
  .fsyncEvent(fsyncEvent), .armed(armed)
);

// File: tb/sim_fsync_arm_ctrl.sv
module sim_fsync_arm_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic updateStrobe = 1'b0;
  logic [1:0] refSel = '0;
  logic [3:0] refValid = '0;
  logic [3:0] refPulse = '0;
  logic syncPin = 1'b0;
  logic selRefValid, fsyncEvent, armed;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fsync_arm_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .updateStrobe(updateStrobe),
    .refSel(refSel), .refValid(refValid), .refPulse(refPulse),
    .syncPin(syncPin), .selRefValid(selRefValid), .fsyncEvent(fsyncEvent),
    .armed(armed)
  );

  // {validate, sel[1:0], valid[3:0], expected}
  localparam logic [7:0] VEC [10] = '{
    8'b0_00_0001_1, 8'b0_00_1110_0, 8'b1_00_0001_0, 8'b1_00_0011_1,
    8'b1_10_0100_0, 8'b1_10_1100_1, 8'b0_10_0100_1, 8'b1_10_1011_0,
    8'b1_01_0010_1, 8'b0_11_1000_1
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic upd();
    updateStrobe = 1'b1;
    @(negedge clk);
    updateStrobe = 1'b0;
    idle(2);
  endtask

  // raise one pulse input, return event seen in the cycle after the edge
  task automatic pulse(input int idx, output logic ev);
    refPulse[idx] = 1'b1;
    @(negedge clk);
    ev = fsyncEvent;
    refPulse[idx] = 1'b0;
    @(negedge clk);
    if (fsyncEvent) ev = 1'bx;
  endtask

  task automatic pinArm();
    syncPin = 1'b1;
    idle(2);
    syncPin = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ev;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rst event", {7'b0, fsyncEvent}, 8'h00);
    check("R1 rst armed", {7'b0, armed}, 8'h00);
    regAddr = 1'b0; #1 check("R1 rst reg0", regRdData, 8'h00);
    regAddr = 1'b1; #1 check("R1 rst reg1", regRdData, 8'h00);

    // R3 validity table
    for (int i = 0; i < 10; i++) begin
      wr(1'b1, {4'b0, VEC[i][7], 3'b000});
      upd();
      refSel = VEC[i][6:5];
      refValid = VEC[i][4:1];
      @(negedge clk);
      check($sformatf("R3 vec%0d", i), {7'b0, selRefValid}, {7'b0, VEC[i][0]});
    end
    refValid = '0;

    // R1 reserved bits read zero
    wr(1'b0, 8'hFF); regAddr = 1'b0; #1 check("R1 reg0 reserved", regRdData, 8'h01);
    wr(1'b1, 8'hF0); regAddr = 1'b1; #1 check("R1 reg1 reserved", regRdData, 8'h00);

    // R2 enable written but not yet updated -> no event
    refSel = 2'd0;
    pulse(1, ev);
    check("R2 no update no event", {7'b0, ev}, 8'h00);
    upd();

    // R4 / R5 continuous mode
    pulse(0, ev); check("R4 non-partner ignored", {7'b0, ev}, 8'h00);
    pulse(1, ev); check("R5 level event 1", {7'b0, ev}, 8'h01);
    pulse(1, ev); check("R5 level event 2", {7'b0, ev}, 8'h01);
    refSel = 2'd2;
    pulse(1, ev); check("R4 wrong pair ignored", {7'b0, ev}, 8'h00);
    pulse(3, ev); check("R4 pair 3 event", {7'b0, ev}, 8'h01);
    refPulse[3] = 1'b1; idle(3);
    check("R4 held level single", {7'b0, fsyncEvent}, 8'h00);
    refPulse[3] = 1'b0; idle(1);

    // R6 / R7 one-shot, pin arming
    wr(1'b1, 8'h04); upd();
    pulse(3, ev); check("R6 unarmed ignored", {7'b0, ev}, 8'h00);
    syncPin = 1'b1; idle(3);
    check("R7 high does not arm", {7'b0, armed}, 8'h00);
    syncPin = 1'b0; @(negedge clk);
    check("R7 fall arms", {7'b0, armed}, 8'h01);
    pulse(3, ev); check("R6 first pulse fires", {7'b0, ev}, 8'h01);
    check("R6 disarmed", {7'b0, armed}, 8'h00);
    pulse(3, ev); check("R6 second ignored", {7'b0, ev}, 8'h00);

    // R8 soft bit ignored with pin method
    wr(1'b1, 8'h05); upd();
    check("R8 soft ignored method0", {7'b0, armed}, 8'h00);
    wr(1'b1, 8'h07); upd();
    check("R8 set held no arm", {7'b0, armed}, 8'h00);
    pinArm();
    check("R8 pin ignored method1", {7'b0, armed}, 8'h00);
    wr(1'b1, 8'h06); upd();
    wr(1'b1, 8'h07); upd();
    check("R8 clear-set arms", {7'b0, armed}, 8'h01);
    pulse(3, ev); check("R8 soft armed fires", {7'b0, ev}, 8'h01);
    pulse(3, ev); check("R8 after fire ignored", {7'b0, ev}, 8'h00);

    // R9 disable clears arm and blocks events
    wr(1'b1, 8'h06); upd();
    wr(1'b1, 8'h07); upd();
    check("R9 armed before disable", {7'b0, armed}, 8'h01);
    wr(1'b0, 8'h00); upd();
    check("R9 disarmed", {7'b0, armed}, 8'h00);
    wr(1'b1, 8'h00); upd();
    pulse(3, ev); check("R9 disabled no event", {7'b0, ev}, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule